// File: doc/BRIEF.md
# Power-Good and On/Off Timing Sequencer

This block sequences a power supply built from an auxiliary converter and a main converter. It takes a remote on/off request (active low), an input-valid flag from the AC sense path, one undervoltage flag per monitored rail, a controller-supply-valid flag and an external fault flag. From these it drives the main converter enable, the power-good flag and one undervoltage blanking window per converter. Analog comparison and fault latching happen elsewhere and reach the block as synchronous digital flags.

An internal prescaler turns the system clock into a millisecond tick, and all long timers count that tick. The on/off request is synchronised and then debounced in ticks. After a turn-on request the main converter is enabled, and power-good follows a fixed settling time after every rail is clear of undervoltage. A turn-off request drops power-good at once. The main converter stays enabled for a short hold-up time, which is counted in clock cycles, and then turns off. While a blanking window is high, a downstream monitor must ignore undervoltage on that converter.

Top module: `pwr_seq`

## Requirements
- R1: The request input `onoff_n_i` (0 = on, 1 = off) is accepted only after its synchronised level has differed from the accepted level on `DEB_TICKS` consecutive ticks. A shorter pulse has no effect on `main_en_o`. After reset the accepted level is off.
- R2: With `vdd_ok_i` and `ac_ok_i` high, `fault_i` low and the accepted request on, `main_en_o` goes high.
- R3: While `main_en_o` is high, `pgood_o` goes high once all bits of `rail_uv_i` (1 = undervoltage) have been 0 for `PG_TICKS` ticks. Any undervoltage bit restarts that wait from zero.
- R4: `pgood_o` drops in the same cycle that the accepted request changes to off.
- R5: After an accepted off request, `main_en_o` stays high for `HOLD_CYC` clock cycles and then goes low.
- R6: If the request returns to on during the hold-up, `main_en_o` stays high and `pgood_o` stays low until a new full `PG_TICKS` wait has elapsed.
- R7: `aux_blank_o` goes high the cycle after `vdd_ok_i` rises and stays high for `BLANK_TICKS` ticks.
- R8: `main_blank_o` goes high the cycle after `ac_ok_i` rises while `vdd_ok_i` is high, and stays high for `BLANK_TICKS` ticks.
- R9: Reset holds all outputs low. In the cycle after `vdd_ok_i` is sampled low, every output is low and the sequencer is idle.
- R10: `fault_i` high or `ac_ok_i` low turns `main_en_o` and `pgood_o` off in the next cycle, with no hold-up.
- R11: `pgood_o` is never high while `main_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| onoff_n_i | input | 1 | Remote on/off request, 0 = on, asynchronous |
| ac_ok_i | input | 1 | AC input voltage valid |
| vdd_ok_i | input | 1 | Controller supply valid |
| fault_i | input | 1 | External fault, forces the main converter off |
| rail_uv_i | input | N_RAILS | Per-rail undervoltage flags, 1 = below threshold |
| main_en_o | output | 1 | Main converter enable |
| pgood_o | output | 1 | Power-good flag |
| aux_blank_o | output | 1 | Undervoltage blanking window, auxiliary converter |
| main_blank_o | output | 1 | Undervoltage blanking window, main converter |

## Verification
The assertions assume that `ac_ok_i`, `vdd_ok_i`, `fault_i` and `rail_uv_i` are already synchronous to `clk_i`. Only the request pin passes through the block's own synchroniser. The bench meets this by changing those flags only on the falling clock edge. It holds the request steady for whole tick multiples, so each debounce outcome is decided by the tick count and not by the tick phase. Every timing check uses a window of at least one tick on either side of the nominal point, because the prescaler phase against the stimulus is not fixed.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OFF  = 3'd1,
    ST_WAIT = 3'd2,
    ST_ON   = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_tick.sv
module pwr_seq_tick #(
  parameter int unsigned DIV = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_deb.sv
module pwr_seq_deb #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_n_i,
  output logic on_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  // two-flop sync, reset to the off level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= raw_n_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(TICKS - 1)) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign on_o = ~lvl_q;
endmodule

// File: rtl/pwr_seq_win.sv
module pwr_seq_win #(
  parameter int unsigned LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  input  logic clr_i,
  output logic act_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start = trig_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_o <= 1'b1;
      cnt_q <= '0;
    end else if (act_o && tick_i) begin
      if (cnt_q == CW'(LEN - 1)) act_o <= 1'b0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_RAILS     = 3,
  parameter int unsigned TICK_DIV    = 100_000,
  parameter int unsigned DEB_TICKS   = 16,
  parameter int unsigned PG_TICKS    = 250,
  parameter int unsigned BLANK_TICKS = 64,
  parameter int unsigned HOLD_CYC    = 250_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               onoff_n_i,
  input  logic               ac_ok_i,
  input  logic               vdd_ok_i,
  input  logic               fault_i,
  input  logic [N_RAILS-1:0] rail_uv_i,
  output logic               main_en_o,
  output logic               pgood_o,
  output logic               aux_blank_o,
  output logic               main_blank_o
);
  localparam int unsigned PW = $clog2(PG_TICKS + 1);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic       tick, deb_on, rails_ok, kill;
  seq_state_e st_q, st_d;
  logic [PW-1:0] pg_cnt_q;
  logic [HW-1:0] hold_cnt_q;

  pwr_seq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  pwr_seq_deb #(.TICKS(DEB_TICKS)) u_deb (
    .clk_i  (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .raw_n_i(onoff_n_i), .on_o(deb_on)
  );

  pwr_seq_win #(.LEN(BLANK_TICKS)) u_win_aux (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .trig_i(vdd_ok_i), .clr_i(~vdd_ok_i), .act_o(aux_blank_o)
  );

  pwr_seq_win #(.LEN(BLANK_TICKS)) u_win_main (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .trig_i(ac_ok_i & vdd_ok_i), .clr_i(~vdd_ok_i), .act_o(main_blank_o)
  );

  assign rails_ok = ~|rail_uv_i;
  assign kill     = fault_i | ~ac_ok_i;

  always_comb begin
    st_d = st_q;
    if (!vdd_ok_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_OFF;
        ST_OFF:  if (deb_on && !kill) st_d = ST_WAIT;
        ST_WAIT: begin
          if (kill)                 st_d = ST_OFF;
          else if (!deb_on)         st_d = ST_HOLD;
          else if (rails_ok && tick && pg_cnt_q == PW'(PG_TICKS - 1))
                                    st_d = ST_ON;
        end
        ST_ON: begin
          if (kill)         st_d = ST_OFF;
          else if (!deb_on) st_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (kill)                                st_d = ST_OFF;
          else if (deb_on)                         st_d = ST_WAIT;
          else if (hold_cnt_q == HW'(HOLD_CYC - 1)) st_d = ST_OFF;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // settle timer restarts on any undervoltage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pg_cnt_q <= '0;
    else if (st_q != ST_WAIT || !rails_ok) pg_cnt_q <= '0;
    else if (tick)                         pg_cnt_q <= pg_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_cnt_q <= '0;
    else if (st_q != ST_HOLD) hold_cnt_q <= '0;
    else                      hold_cnt_q <= hold_cnt_q + 1'b1;
  end

  assign main_en_o = (st_q == ST_WAIT) || (st_q == ST_ON) || (st_q == ST_HOLD);
  assign pgood_o   = (st_q == ST_ON) && deb_on;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned N_RAILS = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ac_ok_i,
  input logic               vdd_ok_i,
  input logic               fault_i,
  input logic [N_RAILS-1:0] rail_uv_i,
  input logic               main_en_o,
  input logic               pgood_o,
  input logic               aux_blank_o,
  input logic               main_blank_o,
  input logic               deb_on_i,
  input logic               tick_i
);
  a_r1_deb_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(deb_on_i) |-> $past(tick_i));

  a_r3_pg_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(rail_uv_i) == '0);

  a_r4_pg_drop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deb_on_i) |-> !pgood_o);

  a_r5_no_abrupt_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_en_o) |-> (!$past(pgood_o) || !$past(vdd_ok_i) ||
                          $past(fault_i) || !$past(ac_ok_i)));

  a_r7_aux_blank_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vdd_ok_i) |=> aux_blank_o);

  a_r8_main_blank_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ac_ok_i) && vdd_ok_i) |=> main_blank_o);

  a_r9_vdd_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vdd_ok_i |=> (!main_en_o && !pgood_o && !aux_blank_o && !main_blank_o));

  a_r10_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i || !ac_ok_i) |=> (!main_en_o && !pgood_o));

  a_r11_pg_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> main_en_o);
endmodule

bind pwr_seq pwr_seq_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ac_ok_i     (ac_ok_i),
  .vdd_ok_i    (vdd_ok_i),
  .fault_i     (fault_i),
  .rail_uv_i   (rail_uv_i),
  .main_en_o   (main_en_o),
  .pgood_o     (pgood_o),
  .aux_blank_o (aux_blank_o),
  .main_blank_o(main_blank_o),
  .deb_on_i    (deb_on),
  .tick_i      (tick)
);

// File: tb/sim_pwr_seq.sv
`timescale 1ns/1ps
module sim_pwr_seq;
  localparam int NR = 3, DIV = 10, DEB = 4, PG = 8, BLK = 6, HOLD = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic onoff_n = 1'b1, ac_ok = 1'b0, vdd_ok = 1'b0, fault = 1'b0;
  logic [NR-1:0] rail_uv = '1;
  logic main_en, pgood, aux_blank, main_blank;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_seq #(.N_RAILS(NR), .TICK_DIV(DIV), .DEB_TICKS(DEB), .PG_TICKS(PG),
            .BLANK_TICKS(BLK), .HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .onoff_n_i(onoff_n), .ac_ok_i(ac_ok),
    .vdd_ok_i(vdd_ok), .fault_i(fault), .rail_uv_i(rail_uv),
    .main_en_o(main_en), .pgood_o(pgood), .aux_blank_o(aux_blank),
    .main_blank_o(main_blank)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait up to lim cycles for sig==val; returns cycles waited or -1
  task automatic wait_pg(input logic val, input int lim, output int k);
    k = -1;
    for (int i = 0; i < lim; i++) begin
      if (pgood === val) begin k = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R9 reset main_en", main_en, 1'b0);
    chk("R9 reset pgood", pgood, 1'b0);
    chk("R9 reset aux_blank", aux_blank, 1'b0);
    chk("R9 reset main_blank", main_blank, 1'b0);
  endtask

  task automatic t_aux_blank;
    vdd_ok = 1'b1;
    cyc(2);
    chk("R7 aux_blank start", aux_blank, 1'b1);
    cyc((BLK - 1) * DIV - 5);
    chk("R7 aux_blank held", aux_blank, 1'b1);
    cyc(DIV + 10);
    chk("R7 aux_blank end", aux_blank, 1'b0);
  endtask

  task automatic t_main_blank;
    ac_ok = 1'b1;
    cyc(2);
    chk("R8 main_blank start", main_blank, 1'b1);
    chk("R2 main_en off without request", main_en, 1'b0);
    cyc((BLK - 1) * DIV - 5);
    chk("R8 main_blank held", main_blank, 1'b1);
    cyc(DIV + 10);
    chk("R8 main_blank end", main_blank, 1'b0);
  endtask

  task automatic t_glitch;
    onoff_n = 1'b0;
    cyc((DEB - 2) * DIV);
    onoff_n = 1'b1;
    cyc((DEB + 2) * DIV);
    chk("R1 short pulse ignored", main_en, 1'b0);
  endtask

  task automatic t_power_on;
    int k;
    onoff_n = 1'b0;
    cyc((DEB + 2) * DIV);
    chk("R2 main_en on", main_en, 1'b1);
    chk("R3 pgood low while rails uv", pgood, 1'b0);
    rail_uv = '0;
    cyc(50);
    rail_uv = 3'b010;
    cyc(2);
    rail_uv = '0;
    cyc((PG - 1) * DIV - 3);
    chk("R3 wait restarted by uv", pgood, 1'b0);
    cyc(DIV + 6);
    chk("R3 pgood after settle", pgood, 1'b1);
    chk("R11 main_en with pgood", main_en, 1'b1);
  endtask

  task automatic t_off_hold;
    int k, m;
    onoff_n = 1'b1;
    wait_pg(1'b0, 200, k);
    chk("R4 pgood dropped on off", pgood, 1'b0);
    chk("R4 main_en still on at drop", main_en, 1'b1);
    m = 0;
    while (main_en === 1'b1 && m < 300) begin
      @(negedge clk);
      m++;
    end
    n_run++;
    if (m < HOLD || m > HOLD + 2) begin
      n_fail++;
      $display("FAIL R5: hold-up %0d cycles expected %0d", m, HOLD + 1);
    end
  endtask

  task automatic t_return;
    int k;
    logic dropped;
    onoff_n = 1'b0;
    wait_pg(1'b1, 400, k);
    chk("R3 pgood up again", pgood, 1'b1);
    onoff_n = 1'b1;
    wait_pg(1'b0, 200, k);
    onoff_n = 1'b0;
    dropped = 1'b0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (main_en !== 1'b1) dropped = 1'b1;
    end
    chk("R6 main_en kept through return", dropped, 1'b0);
    chk("R6 pgood waits again", pgood, 1'b0);
    wait_pg(1'b1, 200, k);
    chk("R6 pgood after new wait", pgood, 1'b1);
  endtask

  task automatic t_kill;
    fault = 1'b1;
    cyc(1);
    chk("R10 fault main_en", main_en, 1'b0);
    chk("R10 fault pgood", pgood, 1'b0);
    fault = 1'b0;
    cyc(2);
    chk("R2 main_en after fault clear", main_en, 1'b1);
    ac_ok = 1'b0;
    cyc(1);
    chk("R10 ac loss main_en", main_en, 1'b0);
    ac_ok = 1'b1;
    cyc(2);
    chk("R8 main_blank restarted", main_blank, 1'b1);
    chk("R2 main_en after ac back", main_en, 1'b1);
  endtask

  task automatic t_vdd_loss;
    vdd_ok = 1'b0;
    cyc(1);
    chk("R9 vdd loss main_en", main_en, 1'b0);
    chk("R9 vdd loss pgood", pgood, 1'b0);
    chk("R9 vdd loss aux_blank", aux_blank, 1'b0);
    chk("R9 vdd loss main_blank", main_blank, 1'b0);
    vdd_ok = 1'b1;
    cyc(2);
    chk("R7 aux_blank on vdd return", aux_blank, 1'b1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_aux_blank();
    t_main_blank();
    t_glitch();
    t_power_on();
    t_off_hold();
    t_return();
    t_kill();
    t_vdd_loss();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule